// File: doc/BRIEF.md
# Page Write Controller with Toggle Polling

This block sits in front of a byte-wide non-volatile array and turns a burst of host byte writes into one timed programming cycle. The first write opens a page: its upper address bits are locked, and it and later writes to the same page are held in a page buffer along with a per-slot loaded mark. Each accepted byte restarts a load window. When the window runs out with no new byte, the controller starts the internal programming cycle on its own. That cycle copies the loaded slots into the array and then holds the array busy for a fixed number of cycles.

While programming runs, the controller does not return array data. Each read instead returns a status byte in which one bit inverts from one read to the next. The host polls by reading back to back and stops once two reads agree, so it can detect the end of programming before the worst-case time has passed. Outside programming, reads return the array contents. The array is a behavioural byte memory inside the block, so the whole flow can be checked end to end.

Top module: `page_prog_ctrl`

## Requirements
- R1: A write while idle opens a page and locks address bits [ADDR_W-1:PAGE_W]. One programming cycle commits from 1 to 2**PAGE_W bytes, with the slot selected by address bits [PAGE_W-1:0].
- R2: During loading, a write whose upper address bits differ from the locked page is dropped and sets `page_err` in the next cycle. The page stays open. `page_err` stays set until the next page is opened, and the write that opens it clears the flag.
- R3: Every accepted byte restarts the load window. A write sampled up to LOAD_CYC clock edges after the previous accepted write still joins the page. If LOAD_CYC edges pass with no accepted write, programming begins.
- R4: Programming lasts PROG_CYC cycles. Counting from the last accepted write, reads sampled at edges LOAD_CYC+1 through LOAD_CYC+PROG_CYC return the status byte. Reads sampled after that return the new array contents.
- R5: In the status byte, bit 6 is the toggle bit and every other bit is 0. The first status read of a programming cycle has bit 6 = 1, and each later status read in that cycle inverts it.
- R6: Writes sampled during programming are dropped. They change neither the array nor `page_err`.
- R7: Only loaded slots are committed, and the other bytes of the page keep their old values. If the same slot is written more than once, the last value wins.
- R8: Outside programming, reads return the array contents, including the old contents while a page is loading. `rd_valid` is high exactly one cycle after `rd_en`, with `rd_data` valid in that cycle.
- R9: After reset the block is idle with `page_err` = 0 and `rd_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Byte write request |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write byte |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | DATA_W | Read result (array byte or status byte) |
| rd_valid | output | 1 | `rd_data` valid, one cycle after `rd_en` |
| page_err | output | 1 | Sticky flag for a dropped write to a foreign page |

## Verification
The bench builds the block with ADDR_W=6, PAGE_W=3, LOAD_CYC=6 and PROG_CYC=20: eight 8-byte pages, a six-cycle load window and a twenty-cycle programming time. With these values, full pages, partial pages, repeated slots and foreign-page writes all run in a few hundred cycles. Writes can be placed exactly on the last edge of the load window and on the first edge after it. A read issued on every cycle across a whole programming cycle sees the old data, each status read in turn, and then the new data.

// File: rtl/pwc_pkg.sv
`timescale 1ns/1ps
package pwc_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_LOAD = 2'd1,
    PS_PROG = 2'd2
  } pstate_e;
endpackage

// File: rtl/pwc_seq.sv
`timescale 1ns/1ps
// Phase sequencer: idle / loading / programming, with load window and
// programming counters. LOAD_CYC >= 2 and PROG_CYC > 2**PAGE_W expected.
module pwc_seq #(
  parameter int PAGE_W   = 7,
  parameter int LOAD_CYC = 100,
  parameter int PROG_CYC = 5000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               same_page,
  output pwc_pkg::pstate_e   state,
  output logic               open,
  output logic               accept,
  output logic               reject,
  output logic               prog_start,
  output logic               prog_end,
  output logic               commit_vld,
  output logic [PAGE_W-1:0]  commit_idx
);
  import pwc_pkg::*;

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int LCW        = $clog2(LOAD_CYC);
  localparam int PCW        = $clog2(PROG_CYC);

  pstate_e          state_q, state_d;
  logic [LCW-1:0]   load_cnt_q, load_cnt_d;
  logic             load_cnt_en;
  logic [PCW-1:0]   prog_cnt_q, prog_cnt_d;
  logic             prog_cnt_en;
  logic             in_idle, in_load, in_prog, load_last;

  always_comb begin
    in_idle    = (state_q == PS_IDLE);
    in_load    = (state_q == PS_LOAD);
    in_prog    = (state_q == PS_PROG);
    open       = wr_en && in_idle;
    accept     = open || (wr_en && in_load && same_page);
    reject     = wr_en && in_load && !same_page;
    load_last  = (load_cnt_q == LCW'(LOAD_CYC - 1));
    prog_start = in_load && !accept && load_last;
    prog_end   = in_prog && (prog_cnt_q == PCW'(PROG_CYC - 1));
    commit_vld = in_prog && (prog_cnt_q < PCW'(PAGE_BYTES));
    commit_idx = prog_cnt_q[PAGE_W-1:0];
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE: if (open)       state_d = PS_LOAD;
      PS_LOAD: if (prog_start) state_d = PS_PROG;
      PS_PROG: if (prog_end)   state_d = PS_IDLE;
      default:                 state_d = PS_IDLE;
    endcase
  end

  always_comb begin
    load_cnt_en = accept || in_load;
    load_cnt_d  = accept ? '0 : load_cnt_q + LCW'(1);
    prog_cnt_en = prog_start || in_prog;
    prog_cnt_d  = prog_start ? '0 : prog_cnt_q + PCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PS_IDLE;
      load_cnt_q <= '0;
      prog_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (load_cnt_en) load_cnt_q <= load_cnt_d;
      if (prog_cnt_en) prog_cnt_q <= prog_cnt_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/pwc_page_buf.sv
`timescale 1ns/1ps
// Page buffer: locked page tag, one data byte and one loaded mark per slot.
module pwc_page_buf #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 7,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     accept,
  input  logic                     open,
  input  logic                     clear,
  input  logic [PAGE_W-1:0]        rd_idx,
  output logic                     same_page,
  output logic [ADDR_W-PAGE_W-1:0] lock_page,
  output logic [DATA_W-1:0]        rd_byte,
  output logic                     rd_vld
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int TAG_W      = ADDR_W - PAGE_W;

  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] slot_data [PAGE_BYTES];
  logic              slot_vld  [PAGE_BYTES];

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    logic              hit;
    logic              vld_q, vld_d;
    logic [DATA_W-1:0] byte_q;

    assign hit = accept && (wr_addr[PAGE_W-1:0] == PAGE_W'(i));

    always_comb begin
      vld_d = vld_q;
      if (clear)     vld_d = 1'b0;
      else if (hit)  vld_d = 1'b1;
      else if (open) vld_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (hit) byte_q <= wr_data;
    end

    assign slot_data[i] = byte_q;
    assign slot_vld[i]  = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tag_q <= '0;
    else if (open) tag_q <= wr_addr[ADDR_W-1:PAGE_W];
  end

  assign same_page = (wr_addr[ADDR_W-1:PAGE_W] == tag_q);
  assign lock_page = tag_q;
  assign rd_byte   = slot_data[rd_idx];
  assign rd_vld    = slot_vld[rd_idx];
endmodule

// File: rtl/pwc_array.sv
`timescale 1ns/1ps
// Behavioural byte array: one write port, one registered read port.
module pwc_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/page_prog_ctrl.sv
`timescale 1ns/1ps
module page_prog_ctrl #(
  parameter int ADDR_W     = 10,
  parameter int PAGE_W     = 7,
  parameter int DATA_W     = 8,
  parameter int TOGGLE_BIT = 6,
  parameter int LOAD_CYC   = 100,
  parameter int PROG_CYC   = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              page_err
);
  import pwc_pkg::*;

  localparam int TAG_W = ADDR_W - PAGE_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_int_n = rst_sync_q;

  pstate_e             state;
  logic                open, accept, reject, prog_start, prog_end;
  logic                commit_vld, same_page, buf_vld;
  logic [PAGE_W-1:0]   commit_idx;
  logic [TAG_W-1:0]    lock_page;
  logic [DATA_W-1:0]   buf_byte, arr_rdata;
  logic                arr_we;
  logic [ADDR_W-1:0]   arr_waddr;
  logic                in_prog;

  pwc_seq #(
    .PAGE_W(PAGE_W), .LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .same_page(same_page),
    .state(state), .open(open), .accept(accept), .reject(reject),
    .prog_start(prog_start), .prog_end(prog_end),
    .commit_vld(commit_vld), .commit_idx(commit_idx)
  );

  pwc_page_buf #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_int_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .accept(accept), .open(open), .clear(prog_end), .rd_idx(commit_idx),
    .same_page(same_page), .lock_page(lock_page),
    .rd_byte(buf_byte), .rd_vld(buf_vld)
  );

  assign arr_we    = commit_vld && buf_vld;
  assign arr_waddr = {lock_page, commit_idx};
  assign in_prog   = (state == PS_PROG);

  pwc_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(buf_byte),
    .re(rd_en), .raddr(rd_addr), .rdata(arr_rdata)
  );

  // status toggle and read-return path
  logic              tgl_q, tgl_d, tgl_en;
  logic              sel_q, vld_q, err_q, err_d;
  logic [DATA_W-1:0] stat_q, stat_d;

  always_comb begin
    tgl_en = prog_start || (rd_en && in_prog);
    tgl_d  = prog_start ? 1'b1 : !tgl_q;
    stat_d = '0;
    stat_d[TOGGLE_BIT] = tgl_q;
    err_d  = err_q;
    if (reject)    err_d = 1'b1;
    else if (open) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tgl_q  <= 1'b1;
      sel_q  <= 1'b0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      vld_q <= rd_en;
      err_q <= err_d;
      if (tgl_en) tgl_q <= tgl_d;
      if (rd_en) begin
        sel_q  <= in_prog;
        stat_q <= stat_d;
      end
    end
  end

  assign rd_data  = sel_q ? stat_q : arr_rdata;
  assign rd_valid = vld_q;
  assign page_err = err_q;
endmodule

// File: rtl/pwc_chk.sv
`timescale 1ns/1ps
module pwc_chk #(
  parameter int ADDR_W     = 10,
  parameter int PAGE_W     = 7,
  parameter int DATA_W     = 8,
  parameter int TOGGLE_BIT = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input pwc_pkg::pstate_e         state,
  input logic                     rd_en,
  input logic                     rd_valid,
  input logic [DATA_W-1:0]        rd_data,
  input logic                     rd_stat,
  input logic                     reject,
  input logic                     prog_end,
  input logic                     page_err,
  input logic                     arr_we,
  input logic [ADDR_W-1:0]        arr_waddr,
  input logic [ADDR_W-PAGE_W-1:0] lock_page
);
  import pwc_pkg::*;

  localparam logic [DATA_W-1:0] TMASK = DATA_W'(1) << TOGGLE_BIT;

  a_r2_err_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> page_err);

  a_r6_err_frozen_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_PROG) |=> $stable(page_err));

  a_r4_prog_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_PROG && !prog_end) |=> (state == PS_PROG));

  a_r4_prog_exits_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_PROG && prog_end) |=> (state == PS_IDLE));

  a_r7_commit_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (state == PS_PROG && arr_waddr[ADDR_W-1:PAGE_W] == lock_page));

  a_r8_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  a_r5_status_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_stat) |-> ((rd_data & ~TMASK) == '0));

  // R5: successive status reads of one programming cycle alternate bit 6
  logic seen_q, last_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      last_q <= 1'b0;
    end else if (state == PS_LOAD) begin
      seen_q <= 1'b0;
    end else if (rd_valid && rd_stat) begin
      seen_q <= 1'b1;
      last_q <= rd_data[TOGGLE_BIT];
    end
  end

  always @(posedge clk) begin
    if (rst_n && rd_valid && rd_stat) begin
      if (seen_q) begin
        a_r5_toggle_alternates: assert (rd_data[TOGGLE_BIT] != last_q);
      end else begin
        a_r5_first_status_one: assert (rd_data[TOGGLE_BIT] == 1'b1);
      end
    end
  end
endmodule

bind page_prog_ctrl pwc_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .TOGGLE_BIT(TOGGLE_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .state(state), .rd_en(rd_en),
  .rd_valid(rd_valid), .rd_data(rd_data), .rd_stat(sel_q), .reject(reject),
  .prog_end(prog_end), .page_err(page_err), .arr_we(arr_we),
  .arr_waddr(arr_waddr), .lock_page(lock_page)
);

// File: tb/page_prog_ctrl_tb_top.sv
`timescale 1ns/1ps
module page_prog_ctrl_tb_top;
  localparam int AW = 6, PW = 3, DW = 8, TB = 6, LC = 6, PC = 20;
  localparam int PB = 1 << PW, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid, page_err;

  always #4 clk = ~clk;

  page_prog_ctrl #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW), .TOGGLE_BIT(TB),
                   .LOAD_CYC(LC), .PROG_CYC(PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .page_err(page_err));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;

  // requirement-level model
  logic [DW-1:0] mdl [DEPTH];
  bit known [DEPTH];
  bit pend = 0, tgl = 1, err_exp = 0;
  int pg = 0, last = 0;
  logic [DW-1:0] pv [PB];
  bit pm [PB];

  logic [DW-1:0] exp_v [$];
  bit            exp_c [$];
  string         exp_t [$];

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // phase of an edge: 0 idle, 1 loading, 2 programming
  function automatic int phase(int c);
    if (!pend) return 0;
    if (c - last <= LC) return 1;
    if (c - last <= LC + PC) return 2;
    for (int i = 0; i < PB; i++)
      if (pm[i]) begin
        mdl[pg * PB + i] = pv[i];
        known[pg * PB + i] = 1;
      end
    pend = 0;
    return 0;
  endfunction

  task automatic wr(int a, logic [DW-1:0] d, string tag);
    int c, ph;
    bit acc;
    c = cyc + 1;
    ph = phase(c);
    acc = 0;
    if (ph == 0) begin
      pend = 1; pg = a / PB; err_exp = 0; acc = 1;
      for (int i = 0; i < PB; i++) pm[i] = 0;
    end else if (ph == 1) begin
      if (a / PB == pg) acc = 1;
      else err_exp = 1;
    end
    if (acc) begin
      pv[a % PB] = d; pm[a % PB] = 1; last = c; tgl = 1;
    end
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk(page_err == err_exp, tag, "page_err after write", page_err, err_exp);
  endtask

  task automatic rd(int a, string tag);
    int c, ph;
    c = cyc + 1;
    ph = phase(c);
    if (ph == 2) begin
      exp_v.push_back(DW'(tgl) << TB); exp_c.push_back(1); exp_t.push_back(tag);
      tgl = !tgl;
    end else begin
      exp_v.push_back(mdl[a]); exp_c.push_back(known[a]); exp_t.push_back(tag);
    end
    rd_en = 1'b1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected read results as they come out
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_v.size() == 0) begin
        chk(0, "R8", "unexpected rd_valid", 1, 0);
      end else begin
        logic [DW-1:0] e;
        bit cr;
        string t;
        e = exp_v.pop_front(); cr = exp_c.pop_front(); t = exp_t.pop_front();
        if (cr) chk(rd_data === e, t, "read data", rd_data, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    fails++;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) known[i] = 0;
    idle(3);
    chk(rd_valid == 1'b0, "R9", "rd_valid in reset", rd_valid, 0);
    chk(page_err == 1'b0, "R9", "page_err in reset", page_err, 0);
    rst_n = 1'b1;
    idle(4);
    chk(rd_valid == 1'b0, "R9", "rd_valid after reset", rd_valid, 0);
    chk(page_err == 1'b0, "R9", "page_err after reset", page_err, 0);

    // R1: full page 0, then poll across programming (R4, R5)
    for (int i = 0; i < PB; i++) wr(i, DW'(8'h10 + i), "R1");
    for (int k = 0; k < LC + PC + 4; k++) rd(3, "R4");
    for (int i = 0; i < PB; i++) rd(i, "R1");

    // R1: full page 1 left to finish on its own
    for (int i = 0; i < PB; i++) wr(PB + i, DW'(8'h20 + i), "R1");
    idle(LC + PC + 2);
    for (int i = 0; i < PB; i++) rd(PB + i, "R1");

    // R7: partial page 0 with a repeated slot; R8 old data while loading
    wr(2, 8'hA5, "R7");
    wr(2, 8'h5A, "R7");
    wr(6, 8'hC3, "R7");
    for (int k = 0; k < LC + PC + 3; k++) rd(6, "R5");
    for (int i = 0; i < PB; i++) rd(i, "R7");

    // R2: foreign-page write dropped, flag sticky, cleared by next page
    wr(17, 8'h31, "R2");
    wr(9, 8'hEE, "R2");
    idle(3);
    chk(page_err == 1'b1, "R2", "page_err held", page_err, 1);
    idle(LC + PC);
    chk(page_err == 1'b1, "R2", "page_err held after prog", page_err, 1);
    wr(26, 8'h77, "R2");
    idle(LC + PC + 2);
    rd(9, "R2");
    rd(17, "R2");
    rd(26, "R2");

    // R3: last edge of the window joins; R6: first edge after is dropped
    wr(24, 8'h41, "R3");
    idle(LC - 1);
    wr(25, 8'h42, "R3");
    idle(LC);
    wr(26, 8'h99, "R6");
    idle(PC + 2);
    rd(24, "R3");
    rd(25, "R3");
    rd(26, "R6");

    idle(4);
    chk(exp_v.size() == 0, "R8", "reads left unanswered", exp_v.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule